// File: doc/BRIEF.md
# Interrupt Request Gating and Selection Front End

This block sits between the interrupt flags of an 8-bit microcontroller's peripherals and its CPU core. Six sources feed it: external request 0, timer 0, external request 1, timer 1, the serial port and timer 2. A software-writable enable register holds one mask bit per source plus a global enable bit. On each machine-cycle polling strobe the block gates every pending flag with its mask and the global enable. It picks the winner in a fixed order and presents the winner's index and vector address to the core.

The core answers with an acknowledge. The block then drops its request until the next poll. It pulses a clear line only for flags that hardware may clear: the timer 0 and timer 1 overflow flags, and an external flag whose input is in edge mode. The serial port flags and both timer 2 flags are left for software to clear. Timer 2 raises a request when either its overflow flag or its external flag is set, and it is seen at the poll of the same machine cycle. The timer 0 and timer 1 flags are set after that cycle's poll point, so they reach the arbiter one poll later.

Top module: `irq_front`

## Requirements
- R1: After reset the enable register reads 0x00 and no request is presented.
- R2: A write to the enable register is read back on the next cycle with bit 6 forced to 0. Bit 6 ignores writes. Bit 7 is the global enable. Bits 0 to 5 enable sources 0 to 5.
- R3: While the global enable (bit 7) is 0, no poll raises a request, whatever the flags and source enable bits.
- R4: A source whose enable bit is 0 never wins a poll, even when its flag is set.
- R5: Source indices are 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2. Among enabled pending sources, the lowest index wins.
- R6: The presented vector equals 0x03 + 8 × index, giving 0x03, 0x0B, 0x13, 0x1B, 0x23 and 0x2B.
- R7: Request, index and vector change only at a clock edge where the poll strobe is high, or when an acknowledge drops the request.
- R8: The timer 2 request is the OR of its overflow flag and its external flag, and it is seen at the first poll after the flag rises.
- R9: A timer 0 or timer 1 flag reaches the arbiter only at the second poll after it rises.
- R10: An acknowledge while a request is presented drops the request on the next edge. An acknowledge while no request is presented has no effect and pulses no clear.
- R11: Acknowledging timer 0 or timer 1 pulses that timer's flag-clear output during the acknowledge cycle, and that timer does not win again until its flag is set anew.
- R12: Acknowledging an external source pulses its clear output only when that input's edge-mode input is 1.
- R13: Acknowledging the serial port or timer 2 pulses no clear output, and the still-set flag wins again at the next poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| poll_stb | input | 1 | One-clock strobe at each machine cycle's polling point |
| ie_we | input | 1 | Enable register write strobe |
| ie_wdata | input | 8 | Enable register write data |
| ie_rdata | output | 8 | Enable register contents |
| ext0_flag | input | 1 | External request 0 flag |
| ext0_edge | input | 1 | External 0 is edge triggered (1) or level (0) |
| ext1_flag | input | 1 | External request 1 flag |
| ext1_edge | input | 1 | External 1 is edge triggered (1) or level (0) |
| tmr0_ovf | input | 1 | Timer 0 overflow flag |
| tmr1_ovf | input | 1 | Timer 1 overflow flag |
| ser_flag | input | 1 | Serial port flag (receive or transmit done) |
| tmr2_ovf | input | 1 | Timer 2 overflow flag |
| tmr2_ext | input | 1 | Timer 2 external event flag |
| irq_req | output | 1 | A request is presented to the core |
| irq_idx | output | 3 | Index of the presented source |
| irq_vec | output | 8 | Vector address of the presented source |
| irq_ack | input | 1 | Core acknowledge of the presented request |
| clr_tmr0 | output | 1 | Clear pulse for the timer 0 overflow flag |
| clr_tmr1 | output | 1 | Clear pulse for the timer 1 overflow flag |
| clr_ext0 | output | 1 | Clear pulse for the external 0 flag |
| clr_ext1 | output | 1 | Clear pulse for the external 1 flag |

## Verification
Request, index and vector are registered at the poll edge and read at the next falling edge. Timer 0 and 1 flags need a second poll before they can win, so the bench polls twice and checks both results. Clear pulses are combinational from the acknowledge and the held index, so they are sampled one nanosecond after the acknowledge is driven, before the edge that drops the request. Enable register reads are checked on the falling edge after the write edge. The bench checks R7 by changing flags across several clocks with no strobe and confirming that the outputs do not move.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int IRQ_NSRC = 6;

   typedef enum logic [2:0] {
      SRC_EXT0 = 3'd0,
      SRC_TMR0 = 3'd1,
      SRC_EXT1 = 3'd2,
      SRC_TMR1 = 3'd3,
      SRC_SER  = 3'd4,
      SRC_TMR2 = 3'd5
   } irq_src_e;

   localparam int IE_GLOBAL_BIT = 7;
   localparam int IE_RSVD_BIT   = 6;
endpackage

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
   parameter int          DW        = 8,
   parameter logic [DW-1:0] IMPL_MASK = 8'hBF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   // unimplemented bits are held at zero by masking the write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (we) rdata <= wdata & IMPL_MASK;
   end
endmodule

// File: rtl/irq_stage.sv
module irq_stage #(
   parameter int               NSRC      = 6,
   parameter logic [NSRC-1:0]  LATE_MASK = 6'b001010
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            poll,
   input  logic [NSRC-1:0] flag_in,
   input  logic [NSRC-1:0] clr,
   output logic [NSRC-1:0] seen
);
   for (genvar g = 0; g < NSRC; g++) begin : g_src
      if (LATE_MASK[g]) begin : g_late
         // flag set after the poll point: carried to the next poll
         logic hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      hold_q <= 1'b0;
            else if (clr[g]) hold_q <= 1'b0;
            else if (poll)   hold_q <= flag_in[g];
         end
         assign seen[g] = hold_q;
      end else begin : g_now
         logic unused_clr;
         assign unused_clr = clr[g];
         assign seen[g]    = flag_in[g];
      end
   end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int NSRC     = 6,
   parameter int IW       = 3,
   parameter int VW       = 8,
   parameter int VEC_BASE = 3,
   parameter int VEC_STEP = 8
) (
   input  logic [NSRC-1:0] pend,
   output logic            hit,
   output logic [IW-1:0]   idx,
   output logic [VW-1:0]   vec
);
   logic [VW-1:0] vtab [NSRC];

   for (genvar g = 0; g < NSRC; g++) begin : g_vec
      assign vtab[g] = VW'(VEC_BASE + VEC_STEP * g);
   end

   always_comb begin
      hit = 1'b0;
      idx = '0;
      vec = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (pend[i]) begin
            hit = 1'b1;
            idx = IW'(i);
            vec = vtab[i];
         end
      end
   end
endmodule

// File: rtl/irq_front.sv
module irq_front #(
   parameter int              NSRC      = irq_pkg::IRQ_NSRC,
   parameter int              DW        = 8,
   parameter int              VW        = 8,
   parameter int              VEC_BASE  = 3,
   parameter int              VEC_STEP  = 8,
   parameter int              GLB_BIT   = irq_pkg::IE_GLOBAL_BIT,
   parameter logic [NSRC-1:0] LATE_MASK = 6'b001010,
   parameter logic [NSRC-1:0] CLR_MASK  = 6'b001111,
   parameter int              IW        = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          poll_stb,
   input  logic          ie_we,
   input  logic [DW-1:0] ie_wdata,
   output logic [DW-1:0] ie_rdata,
   input  logic          ext0_flag,
   input  logic          ext0_edge,
   input  logic          ext1_flag,
   input  logic          ext1_edge,
   input  logic          tmr0_ovf,
   input  logic          tmr1_ovf,
   input  logic          ser_flag,
   input  logic          tmr2_ovf,
   input  logic          tmr2_ext,
   output logic          irq_req,
   output logic [IW-1:0] irq_idx,
   output logic [VW-1:0] irq_vec,
   input  logic          irq_ack,
   output logic          clr_tmr0,
   output logic          clr_tmr1,
   output logic          clr_ext0,
   output logic          clr_ext1
);
   import irq_pkg::*;

   localparam logic [DW-1:0] IMPL_MASK = DW'((1 << NSRC) - 1) | (DW'(1) << GLB_BIT);

   if (NSRC != IRQ_NSRC)
      $error("irq_front: NSRC must match the six wired sources");
   if (GLB_BIT >= DW || GLB_BIT < NSRC)
      $error("irq_front: global enable bit outside the register");
   if ((1 << IW) < NSRC)
      $error("irq_front: IW too narrow for NSRC");
   if (VEC_BASE + VEC_STEP * (NSRC - 1) >= (1 << VW))
      $error("irq_front: vector table exceeds VW");

   logic [DW-1:0]   ie_q;
   logic [NSRC-1:0] raw, seen, pend, clr_v, mode_v;
   logic            hit;
   logic [IW-1:0]   win_idx;
   logic [VW-1:0]   win_vec;
   logic            req_q;
   logic [IW-1:0]   idx_q;
   logic [VW-1:0]   vec_q;
   logic            take;

   irq_en_reg #(.DW(DW), .IMPL_MASK(IMPL_MASK)) u_en (
      .clk(clk), .rst_n(rst_n), .we(ie_we), .wdata(ie_wdata), .rdata(ie_q)
   );

   always_comb begin
      raw           = '0;
      raw[SRC_EXT0] = ext0_flag;
      raw[SRC_TMR0] = tmr0_ovf;
      raw[SRC_EXT1] = ext1_flag;
      raw[SRC_TMR1] = tmr1_ovf;
      raw[SRC_SER]  = ser_flag;
      raw[SRC_TMR2] = tmr2_ovf | tmr2_ext;
      mode_v           = '1;
      mode_v[SRC_EXT0] = ext0_edge;
      mode_v[SRC_EXT1] = ext1_edge;
   end

   irq_stage #(.NSRC(NSRC), .LATE_MASK(LATE_MASK)) u_stage (
      .clk(clk), .rst_n(rst_n), .poll(poll_stb),
      .flag_in(raw), .clr(clr_v), .seen(seen)
   );

   assign pend = seen & ie_q[NSRC-1:0] & {NSRC{ie_q[GLB_BIT]}};

   irq_pick #(.NSRC(NSRC), .IW(IW), .VW(VW), .VEC_BASE(VEC_BASE),
              .VEC_STEP(VEC_STEP)) u_pick (
      .pend(pend), .hit(hit), .idx(win_idx), .vec(win_vec)
   );

   assign take = irq_ack & req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         idx_q <= '0;
         vec_q <= '0;
      end else if (take) begin
         req_q <= 1'b0;
      end else if (poll_stb) begin
         req_q <= hit;
         idx_q <= win_idx;
         vec_q <= win_vec;
      end
   end

   for (genvar g = 0; g < NSRC; g++) begin : g_clr
      if (CLR_MASK[g]) begin : g_hw
         assign clr_v[g] = take && (idx_q == IW'(g)) && mode_v[g];
      end else begin : g_sw
         assign clr_v[g] = 1'b0;
      end
   end

   assign ie_rdata = ie_q;
   assign irq_req  = req_q;
   assign irq_idx  = idx_q;
   assign irq_vec  = vec_q;
   assign clr_tmr0 = clr_v[SRC_TMR0];
   assign clr_tmr1 = clr_v[SRC_TMR1];
   assign clr_ext0 = clr_v[SRC_EXT0];
   assign clr_ext1 = clr_v[SRC_EXT1];
endmodule

// File: rtl/irq_front_chk.sv
module irq_front_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       poll_stb,
   input logic [7:0] ie_rdata,
   input logic       irq_req,
   input logic [2:0] irq_idx,
   input logic [7:0] irq_vec,
   input logic       irq_ack,
   input logic       clr_tmr0,
   input logic       clr_tmr1,
   input logic       clr_ext0,
   input logic       clr_ext1
);
   assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ie_rdata[6] == 1'b0);

   assert_global_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_stb && !ie_rdata[7]) |=> !irq_req);

   assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_idx <= 3'd5));

   assert_vec_form_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_vec[2:0] == 3'b011 && irq_vec[7:3] == {2'b00, irq_idx}));

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!poll_stb && !irq_ack) |=> ($stable(irq_req) && $stable(irq_idx)));

   assert_ack_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_req) |=> !irq_req);

   assert_clr_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({clr_tmr0, clr_tmr1, clr_ext0, clr_ext1}));

   assert_clr_tmr_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_tmr0 || clr_tmr1) |-> (irq_ack && irq_req &&
                                  irq_idx == (clr_tmr0 ? 3'd1 : 3'd3)));

   assert_clr_ext_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_ext0 || clr_ext1) |-> (irq_ack && irq_req &&
                                  irq_idx == (clr_ext0 ? 3'd0 : 3'd2)));

   assert_sw_only_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_idx >= 3'd4) |->
         !(clr_tmr0 || clr_tmr1 || clr_ext0 || clr_ext1));
endmodule

bind irq_front irq_front_chk u_chk (
   .clk(clk), .rst_n(rst_n), .poll_stb(poll_stb), .ie_rdata(ie_rdata),
   .irq_req(irq_req), .irq_idx(irq_idx), .irq_vec(irq_vec), .irq_ack(irq_ack),
   .clr_tmr0(clr_tmr0), .clr_tmr1(clr_tmr1), .clr_ext0(clr_ext0),
   .clr_ext1(clr_ext1)
);

// File: tb/tb_irq_front.sv
`timescale 1ns/1ps
module tb_irq_front;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       poll_stb = 1'b0, ie_we = 1'b0, irq_ack = 1'b0;
   logic [7:0] ie_wdata = '0;
   logic [7:0] ie_rdata;
   logic       ext0_flag = 0, ext0_edge = 0, ext1_flag = 0, ext1_edge = 0;
   logic       tmr0_ovf = 0, tmr1_ovf = 0, ser_flag = 0, tmr2_ovf = 0, tmr2_ext = 0;
   logic       irq_req;
   logic [2:0] irq_idx;
   logic [7:0] irq_vec;
   logic       clr_tmr0, clr_tmr1, clr_ext0, clr_ext1;
   int         total = 0, bad = 0;
   bit         done = 0;

   always #4 clk = ~clk;

   irq_front dut (
      .clk(clk), .rst_n(rst_n), .poll_stb(poll_stb), .ie_we(ie_we),
      .ie_wdata(ie_wdata), .ie_rdata(ie_rdata),
      .ext0_flag(ext0_flag), .ext0_edge(ext0_edge),
      .ext1_flag(ext1_flag), .ext1_edge(ext1_edge),
      .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .ser_flag(ser_flag),
      .tmr2_ovf(tmr2_ovf), .tmr2_ext(tmr2_ext),
      .irq_req(irq_req), .irq_idx(irq_idx), .irq_vec(irq_vec),
      .irq_ack(irq_ack), .clr_tmr0(clr_tmr0), .clr_tmr1(clr_tmr1),
      .clr_ext0(clr_ext0), .clr_ext1(clr_ext1)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // expected vector from the index, per R6
   function automatic int vec_of(input int idx);
      return 3 + 8 * idx;
   endfunction

   task automatic wr_ie(input logic [7:0] d);
      @(negedge clk); ie_we = 1'b1; ie_wdata = d;
      @(negedge clk); ie_we = 1'b0;
   endtask

   task automatic poll();
      @(negedge clk); poll_stb = 1'b1;
      @(negedge clk); poll_stb = 1'b0;
   endtask

   task automatic expect_req(input string tag, input int idx);
      chk({tag, " req"}, irq_req, 1);
      chk({tag, " idx"}, irq_idx, idx);
      chk({tag, " vec"}, irq_vec, vec_of(idx));
   endtask

   // returns {clr_ext1, clr_ext0, clr_tmr1, clr_tmr0} seen during the ack cycle
   task automatic ack(output logic [3:0] clrs);
      @(negedge clk); irq_ack = 1'b1;
      #1 clrs = {clr_ext1, clr_ext0, clr_tmr1, clr_tmr0};
      @(negedge clk); irq_ack = 1'b0;
   endtask

   task automatic clear_flags();
      ext0_flag = 0; ext1_flag = 0; tmr0_ovf = 0; tmr1_ovf = 0;
      ser_flag = 0; tmr2_ovf = 0; tmr2_ext = 0;
   endtask

   task automatic t_reset();
      chk("R1 ie after reset", ie_rdata, 8'h00);
      chk("R1 req after reset", irq_req, 0);
   endtask

   task automatic t_ie_reg();
      wr_ie(8'hFF);
      chk("R2 write FF reads BF", ie_rdata, 8'hBF);
      wr_ie(8'h40);
      chk("R2 bit6 ignores write", ie_rdata, 8'h00);
   endtask

   task automatic t_global();
      wr_ie(8'h3F);
      ext0_flag = 1; ser_flag = 1;
      poll();
      chk("R3 global off no req", irq_req, 0);
      wr_ie(8'h81);
      poll();
      expect_req("R3 global on", 0);
      clear_flags(); poll();
   endtask

   task automatic t_mask();
      logic [3:0] c;
      wr_ie(8'h90);
      ext0_flag = 1; ser_flag = 1;
      poll();
      expect_req("R4 masked ext0 serial wins", 4);
      chk("R6 serial vector", irq_vec, 8'h23);
      ack(c);
      clear_flags(); poll();
   endtask

   task automatic t_priority();
      logic [3:0] c;
      wr_ie(8'hBF);
      ext1_edge = 0; ext1_flag = 1; ser_flag = 1; tmr2_ext = 1;
      poll();
      expect_req("R5 ext1 beats serial", 2);
      ack(c);
      chk("R12 level ext1 no clear", c, 0);
      chk("R10 req dropped after ack", irq_req, 0);
      ext1_flag = 0;
      poll();
      expect_req("R5 serial next", 4);
      ack(c);
      chk("R13 serial no clear", c, 0);
      poll();
      expect_req("R13 serial wins again", 4);
      ack(c);
      ser_flag = 0;
      poll();
      expect_req("R8 tmr2 via ext flag", 5);
      chk("R6 tmr2 vector", irq_vec, 8'h2B);
      ack(c);
      clear_flags(); poll();
      chk("R8 tmr2 gone after sw clear", irq_req, 0);
   endtask

   task automatic t_hold();
      logic [3:0] c;
      ext0_edge = 1; ext0_flag = 1;
      repeat (3) @(negedge clk);
      chk("R7 no change without poll", irq_req, 0);
      poll();
      expect_req("R7 poll takes ext0", 0);
      ext0_flag = 0;
      repeat (2) @(negedge clk);
      chk("R7 idx held without poll", irq_idx, 0);
      ack(c);
      chk("R12 edge ext0 clear", c, 4'b0100);
      poll();
   endtask

   task automatic t_timer_lag();
      logic [3:0] c;
      tmr0_ovf = 1; tmr2_ovf = 1;
      poll();
      expect_req("R8 tmr2 same poll", 5);
      poll();
      expect_req("R9 tmr0 one poll later", 1);
      chk("R6 tmr0 vector", irq_vec, 8'h0B);
      ack(c);
      chk("R11 tmr0 clear", c, 4'b0001);
      tmr0_ovf = 0;
      poll();
      expect_req("R11 tmr0 not again", 5);
      ack(c);
      chk("R13 tmr2 no clear", c, 0);
      poll();
      expect_req("R13 tmr2 again", 5);
      ack(c);
      clear_flags(); poll();
   endtask

   task automatic t_tmr1();
      logic [3:0] c;
      tmr1_ovf = 1;
      poll();
      chk("R9 tmr1 not yet", irq_req, 0);
      poll();
      expect_req("R9 tmr1 second poll", 3);
      ack(c);
      chk("R11 tmr1 clear", c, 4'b0010);
      clear_flags(); poll();
   endtask

   task automatic t_ack_idle();
      logic [3:0] c;
      chk("R10 idle before ack", irq_req, 0);
      ack(c);
      chk("R10 idle ack no clear", c, 0);
      chk("R10 idle ack no req", irq_req, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ie_reg();
      t_global();
      t_mask();
      t_priority();
      t_hold();
      t_timer_lag();
      t_tmr1();
      t_ack_idle();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule